// File: doc/BRIEF.md
# Configuration Register Space Access Unit

This block holds one device's configuration registers behind a simple slave port. Each request carries a 12-bit offset, an access size (byte, 16-bit word or 32-bit dword), a write flag, a path flag that says whether the access arrived on the memory-mapped path, and write data in its natural byte lanes. Exactly one cycle later the block raises a one-cycle completion. For reads, the completion carries the register contents on the lanes that were addressed.

The offset space has two regions. The base region, below `BASE_LIMIT`, takes byte, word and dword accesses. The extended region, above it, takes only dwords, and only on the memory-mapped path. One address-pointer register takes only full dwords. Any access that is illegal for its offset, or misaligned, still completes but changes nothing. If it is a read, it returns all ones together with an error flag. Offsets with no register behind them complete normally, read as zero and ignore writes. Each implemented register has a per-bit writable mask, so bits that are not writable keep their value.

The sample set holds five registers:
- an identity register, read-only;
- a control register with writable bits;
- a strap register, whose low bits come from strap pins and whose second byte is writable;
- the address-pointer register;
- one extended-region register.

A response state machine has three states:
- `ST_IDLE`: no completion this cycle.
- `ST_ACK`: a legal access, or any write, completes.
- `ST_NAK`: an illegal read completes with the error flag set.

From any state, a request with a legal access or a write moves the machine to `ST_ACK`. An illegal read moves it to `ST_NAK`. No request returns it to `ST_IDLE`.

Top module: `cfg_regspace`

## Requirements
- R1: During reset and in the cycle after it, `rsp_valid` and `rsp_err` are 0. After reset, the identity register (offset 0x000) reads `ID_VALUE`, the control register (0x004) reads 0x0000_0004, the address-pointer register (0x0F8) reads 0, and the extended register (0x100) reads 0.
- R2: Bits [STRAP_W-1:0] of the strap register (0x008) hold the value that `strap_in` had in the last reset cycle. Later changes of `strap_in` and any writes leave those bits unchanged.
- R3: Every request cycle is followed in the next cycle by `rsp_valid`=1. A cycle with no request is followed by `rsp_valid`=0. This holds for illegal and reserved accesses too.
- R4: In the base region, byte (`req_size`=0), word (1) and dword (2) reads are accepted. Read data appears on the lanes selected by the offset's low two bits, and the other lanes read zero.
- R5: Storage is little-endian: the byte at offset N+k of a register occupies data bits [8k+7:8k].
- R6: A write changes only the bits that are both in the addressed byte lanes and writable. Control writable mask = 0x0000_FF3F, strap writable mask = 0x0000_FF00, address-pointer mask = 0xFFFF_FFFC, extended mask = 0xFFFF_FFFF. The identity register is read-only.
- R7: An access to an offset with no register behind it completes without error. A read returns 0, and a write has no effect.
- R8: Offsets at or above `BASE_LIMIT` accept only dword accesses with `req_mmio`=1. Any other access there is illegal.
- R9: The address-pointer register accepts only dword accesses. One dword write sets all of its writable bits at once, and a byte or word access to it is illegal.
- R10: A word access at an odd offset, or a dword access at an offset that is not a multiple of 4, is illegal.
- R11: An illegal read completes with `rsp_err`=1 and `rsp_rdata`=0xFFFF_FFFF for one cycle. An illegal write completes with `rsp_err`=0 and changes no state.
- R12: Size code 3 is illegal for every offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mmio | input | 1 | Request arrived on the memory-mapped path |
| req_addr | input | ADDR_W | Byte offset |
| req_size | input | 2 | 0 byte, 1 word, 2 dword, 3 illegal |
| req_wdata | input | 32 | Write data in natural lanes |
| strap_in | input | STRAP_W | Strap pins sampled during reset |
| rsp_valid | output | 1 | One-cycle completion |
| rsp_rdata | output | 32 | Read data in natural lanes |
| rsp_err | output | 1 | Illegal read completion |

## Verification
The bench builds the block with its default parameters: `ADDR_W`=12, `BASE_LIMIT`=256, `STRAP_W`=4 and `ID_VALUE`=0x1A2B_3C4D. With these values, both the base region and the extended register at 0x100 can be addressed, so the region-dependent size rules and the path flag are exercised on real storage. A reserved dword at 0x200 checks the zero-read rule in the extended region. The distinct bytes of the identity value make each lane and endianness check visible. The 4-bit strap value 0xA, followed by a later change to 0x5, separates the reset-time capture from the live pins.

// File: rtl/cfg_regspace_pkg.sv
package cfg_regspace_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int NREG   = 5;

    localparam int IDX_ID    = 0;
    localparam int IDX_CTRL  = 1;
    localparam int IDX_STRAP = 2;
    localparam int IDX_PTR   = 3;
    localparam int IDX_EXT   = 4;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_BAD   = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACK  = 2'd1,
        ST_NAK  = 2'd2
    } rsp_state_e;

    typedef struct packed {
        logic [15:0]       offset;
        logic [DATA_W-1:0] wmask;
        logic [DATA_W-1:0] dflt;
        logic              strap_fill;
        logic              dword_only;
    } reg_desc_t;

    // Register table: offset, writable mask, default, strap fill, dword-only.
    function automatic reg_desc_t reg_desc(input int idx, input logic [DATA_W-1:0] id_val);
        reg_desc_t d;
        d = '0;
        case (idx)
            IDX_ID:    d = '{16'h000, 32'h0000_0000, id_val,        1'b0, 1'b0};
            IDX_CTRL:  d = '{16'h004, 32'h0000_FF3F, 32'h0000_0004, 1'b0, 1'b0};
            IDX_STRAP: d = '{16'h008, 32'h0000_FF00, 32'h0000_0000, 1'b1, 1'b0};
            IDX_PTR:   d = '{16'h0F8, 32'hFFFF_FFFC, 32'h0000_0000, 1'b0, 1'b1};
            IDX_EXT:   d = '{16'h100, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b1};
            default:   d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/cfg_byte_lanes.sv
module cfg_byte_lanes
    import cfg_regspace_pkg::*;
(
    input  logic [1:0]        addr_lo,
    input  logic [1:0]        size,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] lane_mask
);

    always_comb begin
        case (size)
            SZ_BYTE:  be = 4'b0001 << addr_lo;
            SZ_WORD:  be = addr_lo[1] ? 4'b1100 : 4'b0011;
            SZ_DWORD: be = 4'b1111;
            default:  be = 4'b0000;
        endcase
    end

    for (genvar li = 0; li < LANES; li++) begin : g_lane
        assign lane_mask[li*8 +: 8] = {8{be[li]}};
    end

endmodule

// File: rtl/cfg_access_check.sv
module cfg_access_check
    import cfg_regspace_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int BASE_LIMIT = 256
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              mmio,
    output logic              legal,
    output logic [NREG-1:0]   hit
);

    localparam int REGION_LSB = $clog2(BASE_LIMIT);

    logic [NREG-1:0] dword_only_vec;
    logic            in_ext;
    logic            size_ok;
    logic            align_ok;
    logic            region_ok;
    logic            reg_ok;

    for (genvar gi = 0; gi < NREG; gi++) begin : g_dec
        localparam reg_desc_t D = reg_desc(gi, '0);
        localparam logic [ADDR_W-1:0] OFF = ADDR_W'(D.offset);
        assign hit[gi]            = (addr[ADDR_W-1:2] == OFF[ADDR_W-1:2]);
        assign dword_only_vec[gi] = D.dword_only;
    end

    assign in_ext = |addr[ADDR_W-1:REGION_LSB];

    always_comb begin
        size_ok  = (size != SZ_BAD);
        case (size)
            SZ_WORD:  align_ok = ~addr[0];
            SZ_DWORD: align_ok = (addr[1:0] == 2'b00);
            default:  align_ok = 1'b1;
        endcase
        region_ok = !in_ext || (size == SZ_DWORD && mmio);
        reg_ok    = !(|(hit & dword_only_vec)) || (size == SZ_DWORD);
        legal     = size_ok && align_ok && region_ok && reg_ok;
    end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_regspace_pkg::*;
#(
    parameter int                STRAP_W  = 4,
    parameter logic [DATA_W-1:0] ID_VALUE = 32'h1A2B_3C4D
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [NREG-1:0]    hit,
    input  logic [DATA_W-1:0]  lane_mask,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [STRAP_W-1:0] strap_in,
    output logic [DATA_W-1:0]  rd_data
);

    logic [NREG-1:0][DATA_W-1:0] q_vec;

    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        localparam reg_desc_t D = reg_desc(gi, ID_VALUE);
        logic [DATA_W-1:0] q;
        logic [DATA_W-1:0] m;

        assign m = D.wmask & lane_mask;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= D.dflt | (D.strap_fill ? DATA_W'(strap_in) : '0);
            end else if (wr_en && hit[gi]) begin
                q <= (q & ~m) | (wdata & m);
            end
        end

        assign q_vec[gi] = q;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) rd_data = rd_data | q_vec[i];
        end
        rd_data = rd_data & lane_mask;
    end

endmodule

// File: rtl/cfg_regspace.sv
module cfg_regspace
    import cfg_regspace_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter int                BASE_LIMIT = 256,
    parameter int                STRAP_W    = 4,
    parameter logic [DATA_W-1:0] ID_VALUE   = 32'h1A2B_3C4D
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_mmio,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [1:0]         req_size,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [STRAP_W-1:0] strap_in,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               rsp_err
);

    rsp_state_e        state, state_nx;
    logic              legal;
    logic [NREG-1:0]   hit;
    logic [LANES-1:0]  be;
    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] bank_rd;
    logic [DATA_W-1:0] rdata_q;
    logic              wr_en;

    cfg_access_check #(
        .ADDR_W     (ADDR_W),
        .BASE_LIMIT (BASE_LIMIT)
    ) u_check (
        .addr  (req_addr),
        .size  (req_size),
        .mmio  (req_mmio),
        .legal (legal),
        .hit   (hit)
    );

    cfg_byte_lanes u_lanes (
        .addr_lo   (req_addr[1:0]),
        .size      (req_size),
        .be        (be),
        .lane_mask (lane_mask)
    );

    assign wr_en = req_valid && req_write && legal;

    cfg_reg_bank #(
        .STRAP_W  (STRAP_W),
        .ID_VALUE (ID_VALUE)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .hit       (hit),
        .lane_mask (lane_mask),
        .wdata     (req_wdata),
        .strap_in  (strap_in),
        .rd_data   (bank_rd)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        if (!req_valid)                   state_nx = ST_IDLE;
        else if (!legal && !req_write)    state_nx = ST_NAK;
        else                              state_nx = ST_ACK;
    end

    // Read data capture for the completion cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (req_valid) begin
            rdata_q <= (legal && !req_write) ? bank_rd : '0;
        end
    end

    // Outputs
    always_comb begin
        unique case (state)
            ST_IDLE: begin
                rsp_valid = 1'b0;
                rsp_err   = 1'b0;
                rsp_rdata = '0;
            end
            ST_ACK: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b0;
                rsp_rdata = rdata_q;
            end
            ST_NAK: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
                rsp_rdata = '1;
            end
            default: begin
                rsp_valid = 1'b0;
                rsp_err   = 1'b0;
                rsp_rdata = '0;
            end
        endcase
    end

endmodule

// File: rtl/cfg_regspace_chk.sv
module cfg_regspace_chk #(
    parameter int ADDR_W     = 12,
    parameter int BASE_LIMIT = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_mmio,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic              rsp_err
);

    // R3: completion follows each request
    a_r3_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R3: no completion without a request
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R11: error only on a completion, carrying all ones
    a_r11_err_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == 32'hFFFF_FFFF));

    // R11: writes never raise the error flag
    a_r11_write_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> !rsp_err);

    // R12: size code 3 read is an error
    a_r12_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size == 2'd3) |=> rsp_err);

    // R10: misaligned dword read is an error
    a_r10_misaligned_dword: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size == 2'd2 && req_addr[1:0] != 2'b00) |=> rsp_err);

    // R8: extended region read off the memory-mapped path is an error
    a_r8_ext_path: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !req_mmio && int'(req_addr) >= BASE_LIMIT) |=> rsp_err);

endmodule

bind cfg_regspace cfg_regspace_chk #(
    .ADDR_W     (ADDR_W),
    .BASE_LIMIT (BASE_LIMIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_mmio  (req_mmio),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
);

// File: tb/cfg_regspace_bench.sv
`timescale 1ns/1ps
module cfg_regspace_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_mmio = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  strap_in = 4'hA;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;

    int total = 0;
    int bad = 0;

    logic        got_v;
    logic [31:0] got_d;
    logic        got_e;

    always #5 clk = ~clk;

    cfg_regspace u_cfg_regspace (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_mmio  (req_mmio),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .strap_in  (strap_in),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic mm, input logic [11:0] a,
                       input logic [1:0] sz, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_mmio = mm;
        req_addr = a; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        got_v = rsp_valid; got_d = rsp_rdata; got_e = rsp_err;
    endtask

    task automatic rd(input string tag, input logic mm, input logic [11:0] a,
                      input logic [1:0] sz, input logic [31:0] exp_d, input logic exp_e);
        acc(1'b0, mm, a, sz, 32'h0);
        chk({tag, " valid"}, {31'b0, got_v}, 32'd1);
        chk({tag, " data"}, got_d, exp_d);
        chk({tag, " err"}, {31'b0, got_e}, {31'b0, exp_e});
    endtask

    task automatic wr(input string tag, input logic mm, input logic [11:0] a,
                      input logic [1:0] sz, input logic [31:0] wd);
        acc(1'b1, mm, a, sz, wd);
        chk({tag, " wvalid"}, {31'b0, got_v}, 32'd1);
        chk({tag, " werr"}, {31'b0, got_e}, 32'd0);
    endtask

    task automatic t_reset;
        chk("R1 idle valid", {31'b0, rsp_valid}, 32'd0);
        chk("R1 idle err", {31'b0, rsp_err}, 32'd0);
        rd("R1 id", 1'b0, 12'h000, 2'd2, 32'h1A2B_3C4D, 1'b0);
        rd("R1 ctrl", 1'b0, 12'h004, 2'd2, 32'h0000_0004, 1'b0);
        rd("R1 ptr", 1'b0, 12'h0F8, 2'd2, 32'h0, 1'b0);
        rd("R1 ext", 1'b1, 12'h100, 2'd2, 32'h0, 1'b0);
    endtask

    task automatic t_strap;
        strap_in = 4'h5;
        rd("R2 strap kept", 1'b0, 12'h008, 2'd2, 32'h0000_000A, 1'b0);
        wr("R2 strap wr", 1'b0, 12'h008, 2'd2, 32'hFFFF_FFFF);
        rd("R6 strap mask", 1'b0, 12'h008, 2'd2, 32'h0000_FF0A, 1'b0);
    endtask

    task automatic t_lanes;
        rd("R4 byte1", 1'b0, 12'h001, 2'd0, 32'h0000_3C00, 1'b0);
        rd("R4 byte3", 1'b0, 12'h003, 2'd0, 32'h1A00_0000, 1'b0);
        rd("R4 word2", 1'b0, 12'h002, 2'd1, 32'h1A2B_0000, 1'b0);
        wr("R6 id ro", 1'b0, 12'h000, 2'd2, 32'h0);
        rd("R6 id kept", 1'b0, 12'h000, 2'd2, 32'h1A2B_3C4D, 1'b0);
    endtask

    task automatic t_endian;
        wr("R5 byte5", 1'b0, 12'h005, 2'd0, 32'h0000_AB00);
        rd("R5 ctrl hi", 1'b0, 12'h004, 2'd2, 32'h0000_AB04, 1'b0);
        wr("R6 byte4", 1'b0, 12'h004, 2'd0, 32'h0000_00FF);
        rd("R6 ctrl word", 1'b0, 12'h004, 2'd1, 32'h0000_AB3F, 1'b0);
        rd("R5 byte5 rd", 1'b0, 12'h005, 2'd0, 32'h0000_AB00, 1'b0);
    endtask

    task automatic t_misalign;
        rd("R10 word odd", 1'b0, 12'h001, 2'd1, 32'hFFFF_FFFF, 1'b1);
        rd("R10 dword off2", 1'b0, 12'h006, 2'd2, 32'hFFFF_FFFF, 1'b1);
        wr("R10 wr odd", 1'b0, 12'h005, 2'd1, 32'hFFFF_FFFF);
        rd("R10 ctrl kept", 1'b0, 12'h004, 2'd2, 32'h0000_AB3F, 1'b0);
    endtask

    task automatic t_size3;
        rd("R12 rd", 1'b0, 12'h004, 2'd3, 32'hFFFF_FFFF, 1'b1);
        wr("R12 wr", 1'b0, 12'h004, 2'd3, 32'hFFFF_FFFF);
        rd("R12 kept", 1'b0, 12'h004, 2'd2, 32'h0000_AB3F, 1'b0);
        wr("R6 ctrl all", 1'b0, 12'h004, 2'd2, 32'hFFFF_FFFF);
        rd("R6 ctrl mask", 1'b0, 12'h004, 2'd2, 32'h0000_FF3F, 1'b0);
    endtask

    task automatic t_reserved;
        rd("R7 rd 0c", 1'b0, 12'h00C, 2'd2, 32'h0, 1'b0);
        wr("R7 wr 0c", 1'b0, 12'h00C, 2'd2, 32'hFFFF_FFFF);
        rd("R7 rd 0c again", 1'b0, 12'h00C, 2'd2, 32'h0, 1'b0);
        rd("R7 byte 20", 1'b0, 12'h020, 2'd0, 32'h0, 1'b0);
        rd("R7 ext 200", 1'b1, 12'h200, 2'd2, 32'h0, 1'b0);
    endtask

    task automatic t_ext;
        wr("R8 ext wr", 1'b1, 12'h100, 2'd2, 32'hDEAD_BEEF);
        rd("R8 ext rd", 1'b1, 12'h100, 2'd2, 32'hDEAD_BEEF, 1'b0);
        rd("R8 ext word", 1'b1, 12'h100, 2'd1, 32'hFFFF_FFFF, 1'b1);
        rd("R8 ext nommio", 1'b0, 12'h100, 2'd2, 32'hFFFF_FFFF, 1'b1);
        wr("R11 ext bad wr", 1'b0, 12'h100, 2'd2, 32'h0);
        rd("R11 ext kept", 1'b1, 12'h100, 2'd2, 32'hDEAD_BEEF, 1'b0);
    endtask

    task automatic t_ptr;
        wr("R9 ptr wr", 1'b0, 12'h0F8, 2'd2, 32'h8000_1235);
        rd("R9 ptr rd", 1'b0, 12'h0F8, 2'd2, 32'h8000_1234, 1'b0);
        rd("R9 ptr byte", 1'b0, 12'h0F8, 2'd0, 32'hFFFF_FFFF, 1'b1);
        rd("R9 ptr word", 1'b0, 12'h0FA, 2'd1, 32'hFFFF_FFFF, 1'b1);
        wr("R9 ptr byte wr", 1'b0, 12'h0F9, 2'd0, 32'h0000_5500);
        rd("R9 ptr kept", 1'b0, 12'h0F8, 2'd2, 32'h8000_1234, 1'b0);
    endtask

    task automatic t_timing;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_mmio = 1'b0;
        req_addr = 12'h000; req_size = 2'd2;
        @(negedge clk);
        chk("R3 b2b first valid", {31'b0, rsp_valid}, 32'd1);
        chk("R3 b2b first data", rsp_rdata, 32'h1A2B_3C4D);
        req_addr = 12'h008;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3 b2b second valid", {31'b0, rsp_valid}, 32'd1);
        chk("R3 b2b second data", rsp_rdata, 32'h0000_FF0A);
        @(negedge clk);
        chk("R3 pulse ends", {31'b0, rsp_valid}, 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_strap;
        t_lanes;
        t_endian;
        t_misalign;
        t_size3;
        t_reserved;
        t_ext;
        t_ptr;
        t_timing;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule